// File: doc/BRIEF.md
# Watchdog Timer with Register Access

This block is a watchdog for a processor subsystem. Software programs it through a small register window with an address, a write strobe, write data and combinational read data. Once armed, a down-counter runs from a power-of-two period. Software must restart the counter before it reaches zero by writing a fixed key value. If the counter runs out, the block either pulses a system reset straight away or first raises an interrupt and gives software one more period.

The period is picked from sixteen selections, each twice the one before. The shortest is 2^BASE_EXP cycles, and BASE_EXP defaults to 16. Two selections are held: one applies only when the watchdog is first armed, and the other applies to every later reload. Arming is one-way. Once enabled, software cannot disable the block, and only the block's own reset clears the enable.

Top module: `wdog_timer`

## Requirements
- R1: After reset, enable, mode, both timeout selections, `irq_o` and `sys_rst_o` are all 0. The count reads 2^BASE_EXP.
- R2: Control register at offset 0x00: bit 0 = enable, bit 1 = mode. Writing 1 to bit 0 sets the enable, and writing 0 never clears it. Bit 1 takes each written value. A read returns {30'b0, mode, enable}.
- R3: Range register at offset 0x04: bits 3:0 = running selection, bits 7:4 = arming selection. Both can be written at any time, and a read returns them in the same positions.
- R4: Selection s stands for 2^(BASE_EXP+s) cycles. While disabled, the count (read at offset 0x08) equals the value of the arming selection. While enabled, it drops by one per clock, so arming starts the run from the arming selection.
- R5: While enabled, writing exactly 0x00000076 to offset 0x0C reloads the count from the running selection on the next edge and clears `irq_o`.
- R6: A write of any other value to offset 0x0C changes neither the count nor `irq_o`.
- R7: When the count is 0 while enabled, the next edge reloads it from the running selection. In mode 0, `sys_rst_o` is then high for exactly RST_CYCLES (8) clocks.
- R8: In mode 1, an expiry with `irq_o` low sets `irq_o` and does not reset. An expiry with `irq_o` still high starts the reset pulse.
- R9: While disabled, the block raises neither `irq_o` nor `sys_rst_o`.
- R10: Reads of offset 0x0C and of every unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Expiry warning, held until a valid restart |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bound checker checks these properties on every cycle:
- the enable never falls;
- the reset pulse always has its fixed length;
- a disabled block stays silent;
- a valid key clears the interrupt;
- a wrong key leaves the countdown running;
- unmapped reads return zero.

Only the bench's scenarios show the exact period of each selection and the arming-versus-running selection. They also show the two-stage interrupt-then-reset sequence and the exact cycle on which each expiry lands. The bench shows these by comparing against a behavioural model on every clock.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int BASE_EXP   = 16,
  parameter int RST_CYCLES = 8,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int CNT_W = BASE_EXP + 16;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_RANGE = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_KICK  = ADDR_W'(8'h0C);
  localparam logic [31:0] KEY = 32'h0000_0076;

  logic             en, mode;
  logic [3:0]       run_sel, arm_sel;
  logic [CNT_W-1:0] count;
  logic [RC_W-1:0]  rc;

  function automatic logic [CNT_W-1:0] span(input logic [3:0] s);
    return CNT_W'(1) << (BASE_EXP + int'(s));
  endfunction

  wire kick    = wr_en && addr == OFS_KICK && wr_data == KEY;
  wire expire  = en && !kick && count == '0;
  wire fire    = expire && !(mode && !irq_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      mode    <= 1'b0;
      run_sel <= 4'd0;
      arm_sel <= 4'd0;
    end else if (wr_en) begin
      if (addr == OFS_CTRL) begin
        en   <= en | wr_data[0];
        mode <= wr_data[1];
      end
      if (addr == OFS_RANGE) begin
        run_sel <= wr_data[3:0];
        arm_sel <= wr_data[7:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= span(4'd0);
    else if (!en)             count <= span(arm_sel);
    else if (kick || expire)  count <= span(run_sel);
    else                      count <= count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq_o <= 1'b0;
    else if (en && kick)             irq_o <= 1'b0;
    else if (expire && mode)         irq_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rc <= '0;
    else if (fire)      rc <= RC_W'(RST_CYCLES);
    else if (rc != '0)  rc <= rc - RC_W'(1);
  end

  assign sys_rst_o = rc != '0;

  always_comb begin
    case (addr)
      OFS_CTRL:  rd_data = {30'b0, mode, en};
      OFS_RANGE: rd_data = {24'b0, arm_sel, run_sel};
      OFS_COUNT: rd_data = 32'(count);
      default:   rd_data = 32'b0;
    endcase
  end
endmodule

module wdog_timer_chk #(
  parameter int RST_CYCLES = 8,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic              en,
  input logic [CNT_W-1:0]  count
);
  logic [7:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run <= 8'd0;
    else if (sys_rst_o) run <= run + 8'd1;
    else                run <= 8'd0;
  end

  wire is_kick_addr = wr_en && addr == ADDR_W'(8'h0C);

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> int'(run) < RST_CYCLES);
  assert_pulse_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> int'(run) == RST_CYCLES);
  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_o && !sys_rst_o);
  assert_key_clears_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_kick_addr && wr_data == 32'h76) |=> !irq_o);
  assert_bad_key_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_kick_addr && wr_data != 32'h76 && count != '0) |=>
      count == $past(count) - CNT_W'(1) && irq_o == $past(irq_o));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != ADDR_W'(8'h00) && addr != ADDR_W'(8'h04) && addr != ADDR_W'(8'h08))
      |-> rd_data == 32'b0);
endmodule

bind wdog_timer wdog_timer_chk #(
  .RST_CYCLES(RST_CYCLES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .irq_o(irq_o), .sys_rst_o(sys_rst_o), .en(en), .count(count)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
  localparam int BASE = 4;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq_o, sys_rst_o;
  int compared = 0, mismatched = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  wdog_timer #(.BASE_EXP(BASE), .RST_CYCLES(8), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_o(irq_o), .sys_rst_o(sys_rst_o));

  int m_en, m_mode, m_top, m_init, m_irq, m_rc;
  longint m_cnt;

  function automatic longint pw(int s);
    return longint'(1) << (BASE + s);
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return 32'(m_mode * 2 + m_en);
      8'h04: return 32'(m_init * 16 + m_top);
      8'h08: return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_top = 0; m_init = 0; m_irq = 0; m_rc = 0; m_cnt = pw(0);
    end else begin
      bit kick, boom;
      kick = wr_en && addr == 8'h0C && wr_data == 32'h76;
      boom = 0;
      if (m_en == 0) m_cnt = pw(m_init);
      else if (kick) begin m_cnt = pw(m_top); m_irq = 0; end
      else if (m_cnt == 0) begin
        m_cnt = pw(m_top);
        if (m_mode == 1 && m_irq == 0) m_irq = 1; else boom = 1;
        if (m_mode == 1) m_irq = 1;
      end else m_cnt = m_cnt - 1;
      if (boom) m_rc = 8; else if (m_rc > 0) m_rc = m_rc - 1;
      if (wr_en && addr == 8'h00) begin
        if (wr_data[0]) m_en = 1;
        m_mode = int'(wr_data[1]);
      end
      if (wr_en && addr == 8'h04) begin
        m_top = int'(wr_data[3:0]); m_init = int'(wr_data[7:4]);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk({phase, " rd_data"}, rd_data, exp_rd(addr));
    chk({phase, " irq_o"}, 32'(irq_o), 32'(m_irq));
    chk({phase, " sys_rst_o"}, 32'(sys_rst_o), 32'(m_rc != 0));
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1; addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); #1; wr_en = 0;
  endtask

  task automatic look(logic [7:0] a);
    @(negedge clk); #1; addr = a;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    #9 rst_n = 1;
    phase = "R1";
    look(8'h00); @(negedge clk); chk("R1 ctrl", rd_data, 32'h0);
    look(8'h04); @(negedge clk); chk("R1 range", rd_data, 32'h0);
    look(8'h08); @(negedge clk); chk("R1 count", rd_data, 32'(1 << BASE));
    chk("R1 irq", 32'(irq_o), 0); chk("R1 rst", 32'(sys_rst_o), 0);

    phase = "R3";
    wr(8'h04, 32'h21);
    look(8'h04); @(negedge clk); chk("R3 range readback", rd_data, 32'h21);

    phase = "R9";
    wr(8'h00, 32'h2);
    look(8'h08); idle(150);
    chk("R4 disabled count follows arming selection", rd_data, 32'(1 << (BASE + 2)));
    chk("R9 no irq when off", 32'(irq_o), 0);

    phase = "R4";
    wr(8'h00, 32'h1);
    look(8'h08); @(negedge clk);
    chk("R4 armed count started from arming selection", rd_data, 32'((1 << (BASE + 2)) - 2));
    idle(20);

    phase = "R6";
    wr(8'h0C, 32'h77); wr(8'h0C, 32'h176); wr(8'h0C, 32'h0);
    look(8'h08); idle(3);

    phase = "R5";
    wr(8'h0C, 32'h76);
    look(8'h08); idle(1);
    chk("R5 reloaded from running selection", rd_data, 32'((1 << (BASE + 1)) - 2));

    phase = "R2";
    wr(8'h00, 32'h0);
    look(8'h00); @(negedge clk); chk("R2 enable sticks", rd_data, 32'h1);

    phase = "R7";
    look(8'h08); idle(90);

    phase = "R8";
    wr(8'h00, 32'h3);
    wr(8'h0C, 32'h76);
    idle(40);
    chk("R8 irq raised after first expiry", 32'(irq_o), 1);
    wr(8'h0C, 32'h76);
    idle(2);
    chk("R5 irq cleared by key", 32'(irq_o), 0);
    idle(80);

    phase = "R10";
    look(8'h0C); @(negedge clk); chk("R10 kick offset reads zero", rd_data, 0);
    look(8'h10); @(negedge clk); chk("R10 unmapped reads zero", rd_data, 0);
    look(8'hFC); idle(5);

    summary();
  end
endmodule